// File: doc/BRIEF.md
# Calendar Counter with Masked Alarm

This block keeps calendar time in binary fields: seconds, minutes, hours, day of month, day of week, month and a year offset from 2000 that spans 2000 to 2127. A one-cycle pulse on the second-tick input advances the time by one second. Carries ripple through minutes, hours and days. The day of month follows Gregorian month lengths, including the leap rule for the covered span.

An alarm word and a seven-bit field mask feed a comparator. On each second tick the comparator checks the time value the counter is about to take against the alarm. Any field whose mask bit is set is left out of the comparison.

The block keeps two sticky status flags, one for the alarm and one for the tick. Each flag is gated by its own enable bit. A one-shot option disarms the alarm after its first hit. A read strobe clears both flags, and an active-low level interrupt follows them. The register decode and the commit logic sit outside this block. Host writes arrive here as single-cycle load strobes carrying the full value.

Top module: `cal_alarm_top`

## Requirements
- R1: Synchronous active-high reset sets the time word to year offset 0, month 1, day of month 1, day of week 1, 00:00:00. It also clears status, enables, alarm and mask, and drives the interrupt high.
- R2: A time word packs seconds in [5:0], minutes in [11:6], hours in [16:12], day of month in [21:17], day of week in [24:22], month in [28:25] and year offset in [35:29]. A time load is visible on `time_o` one cycle later, and it wins over a tick in the same cycle.
- R3: On a tick, seconds step by one and wrap 59 to 0, carrying into minutes. Minutes wrap 59 to 0, carrying into hours. Hours wrap 23 to 0, carrying into the day.
- R4: The day of month wraps to 1 after the month's last day, which is 30 or 31 by month. February has 29 days when the year offset is divisible by 4 and is not 100, and 28 days otherwise. Month 12 wraps to 1 and increments the year. Year offset 127 wraps to 0.
- R5: Day of week counts 1 to 7 and steps on every day carry, with 7 followed by 1.
- R6: On a tick without a time load, the alarm flag (status bit 0) sets on the same edge that the time updates, provided two conditions hold. The new time must equal the alarm word in every field whose mask bit is clear, and alarm enable (enable bit 0) must be 1. Mask bit i excludes field i in the order seconds, minutes, hours, day of month, day of week, month, year, so bit 4 excludes day of week.
- R7: Every tick sets the tick flag (status bit 1) while tick enable (enable bit 1) is 1. With tick enable 0, a tick leaves that flag unchanged.
- R8: With one-shot (enable bit 2) set, an alarm hit clears enable bit 0 on the same edge and leaves bit 2 set. An enable load in that cycle takes priority. Without one-shot, enable bit 0 stays set after a hit.
- R9: A status read strobe clears both flags on the next edge. A flag that is being set in the same cycle stays set.
- R10: `irq_n_o` is low exactly while any status flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| time_ld_i | input | 1 | Load strobe for the time word |
| time_val_i | input | 36 | Time word to load (R2 layout) |
| alm_ld_i | input | 1 | Load strobe for the alarm word |
| alm_val_i | input | 36 | Alarm word (R2 layout) |
| mask_ld_i | input | 1 | Load strobe for the alarm field mask |
| mask_val_i | input | 7 | Field mask, bit set excludes the field |
| ien_ld_i | input | 1 | Load strobe for the enable bits |
| ien_val_i | input | 3 | Enables: bit0 alarm, bit1 tick, bit2 one-shot |
| sts_rd_i | input | 1 | Status read strobe, clears flags |
| time_o | output | 36 | Current time word |
| sts_o | output | 2 | Status: bit0 alarm, bit1 tick |
| ien_o | output | 3 | Current enable bits |
| irq_n_o | output | 1 | Active-low level interrupt |

## Verification
The calendar is swept near-exhaustively. For each of six year offsets, chosen to include ordinary, leap, the century exception 100 and the wrap year 127, every valid day of every month is loaded at 23:59:59 and ticked once. This separates day-end, month-end, leap-February and year-wrap handling. A run of 4000 consecutive ticks then checks the second, minute and hour carries against a model.

The alarm is tried under several setups:
- a day-of-week mismatch with and without mask bit 4;
- the seconds field masked;
- alarm enable off;
- one-shot set and clear.

Together these show whether masking, gating and self-disarming act separately. Tick-flag gating, read clear, and a read colliding with a set each get their own stimulus.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int MDAY_W = 5;
    localparam int WDAY_W = 3;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 7;

    localparam int NFIELD = 7;
    localparam int TIME_W = SEC_W + MIN_W + HOUR_W + MDAY_W + WDAY_W + MON_W + YEAR_W;

    localparam int EN_ALARM   = 0;
    localparam int EN_TICK    = 1;
    localparam int EN_ONESHOT = 2;
    localparam int EN_W       = 3;

    localparam int ST_ALARM = 0;
    localparam int ST_TICK  = 1;
    localparam int ST_W     = 2;

    localparam int LEAP_SKIP_YEAR = 100;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  mon;
        logic [WDAY_W-1:0] wday;
        logic [MDAY_W-1:0] mday;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_time_t;

    localparam cal_time_t TIME_RESET = '{year: '0, mon: MON_W'(1), wday: WDAY_W'(1),
                                         mday: MDAY_W'(1), hour: '0, min: '0, sec: '0};

    // field index 0..6: sec, min, hour, mday, wday, mon, year
    function automatic int fld_w(input int idx);
        case (idx)
            0: return SEC_W;
            1: return MIN_W;
            2: return HOUR_W;
            3: return MDAY_W;
            4: return WDAY_W;
            5: return MON_W;
            default: return YEAR_W;
        endcase
    endfunction

    function automatic int fld_lsb(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) acc += fld_w(k);
        return acc;
    endfunction

    function automatic logic is_leap(input logic [YEAR_W-1:0] yr);
        return (yr[1:0] == 2'b00) && (yr != YEAR_W'(LEAP_SKIP_YEAR));
    endfunction

    function automatic logic [MDAY_W-1:0] days_in_month(input logic [MON_W-1:0] mo,
                                                         input logic [YEAR_W-1:0] yr);
        case (mo)
            MON_W'(2):                              return is_leap(yr) ? MDAY_W'(29) : MDAY_W'(28);
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): return MDAY_W'(30);
            default:                                return MDAY_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/cal_counter.sv
module cal_counter
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      ld,
    input  cal_time_t ld_val,
    output cal_time_t cur,
    output cal_time_t nxt
);

    logic [MDAY_W-1:0] month_len;
    logic c_sec, c_min, c_hour, c_day, c_mon;

    assign month_len = days_in_month(cur.mon, cur.year);

    always_comb begin
        nxt    = cur;
        c_sec  = (cur.sec  >= SEC_W'(59));
        c_min  = c_sec  && (cur.min  >= MIN_W'(59));
        c_hour = c_min  && (cur.hour >= HOUR_W'(23));
        c_day  = c_hour && (cur.mday >= month_len);
        c_mon  = c_day  && (cur.mon  >= MON_W'(12));

        nxt.sec = c_sec ? '0 : cur.sec + SEC_W'(1);
        if (c_sec)
            nxt.min = c_min ? '0 : cur.min + MIN_W'(1);
        if (c_min)
            nxt.hour = c_hour ? '0 : cur.hour + HOUR_W'(1);
        if (c_hour) begin
            nxt.wday = (cur.wday >= WDAY_W'(7)) ? WDAY_W'(1) : cur.wday + WDAY_W'(1);
            nxt.mday = c_day ? MDAY_W'(1) : cur.mday + MDAY_W'(1);
        end
        if (c_day)
            nxt.mon = c_mon ? MON_W'(1) : cur.mon + MON_W'(1);
        if (c_mon)
            nxt.year = cur.year + YEAR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= TIME_RESET;
        else if (ld)
            cur <= ld_val;
        else if (tick)
            cur <= nxt;
    end

endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alm_ld,
    input  cal_time_t         alm_val,
    input  logic              mask_ld,
    input  logic [NFIELD-1:0] mask_val,
    input  cal_time_t         probe,
    output logic              match
);

    cal_time_t         alm_q;
    logic [NFIELD-1:0] mask_q;
    logic [NFIELD-1:0] field_ok;
    logic [TIME_W-1:0] probe_flat;
    logic [TIME_W-1:0] alm_flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q  <= '0;
            mask_q <= '0;
        end else begin
            if (alm_ld)  alm_q  <= alm_val;
            if (mask_ld) mask_q <= mask_val;
        end
    end

    assign probe_flat = probe;
    assign alm_flat   = alm_q;

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        localparam int L = fld_lsb(g);
        localparam int W = fld_w(g);
        assign field_ok[g] = mask_q[g] || (probe_flat[L +: W] == alm_flat[L +: W]);
    end

    assign match = &field_ok;

endmodule

// File: rtl/cal_irq_ctrl.sv
module cal_irq_ctrl
    import cal_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            time_ld,
    input  logic            match,
    input  logic            ien_ld,
    input  logic [EN_W-1:0] ien_val,
    input  logic            sts_rd,
    output logic [ST_W-1:0] sts,
    output logic [EN_W-1:0] ien,
    output logic            irq_n
);

    logic alarm_hit;
    logic tick_hit;

    assign alarm_hit = tick && !time_ld && match && ien[EN_ALARM];
    assign tick_hit  = tick && ien[EN_TICK];

    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
            ien <= '0;
        end else begin
            sts[ST_ALARM] <= alarm_hit || (sts[ST_ALARM] && !sts_rd);
            sts[ST_TICK]  <= tick_hit  || (sts[ST_TICK]  && !sts_rd);
            if (ien_ld)
                ien <= ien_val;
            else if (alarm_hit && ien[EN_ONESHOT])
                ien[EN_ALARM] <= 1'b0;
        end
    end

    assign irq_n = ~(|sts);

endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              time_ld_i,
    input  logic [TIME_W-1:0] time_val_i,
    input  logic              alm_ld_i,
    input  logic [TIME_W-1:0] alm_val_i,
    input  logic              mask_ld_i,
    input  logic [NFIELD-1:0] mask_val_i,
    input  logic              ien_ld_i,
    input  logic [EN_W-1:0]   ien_val_i,
    input  logic              sts_rd_i,
    output logic [TIME_W-1:0] time_o,
    output logic [ST_W-1:0]   sts_o,
    output logic [EN_W-1:0]   ien_o,
    output logic              irq_n_o
);

    cal_time_t cur_time;
    cal_time_t nxt_time;
    logic      alm_match;

    cal_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_i),
        .ld     (time_ld_i),
        .ld_val (cal_time_t'(time_val_i)),
        .cur    (cur_time),
        .nxt    (nxt_time)
    );

    cal_alarm_unit u_alm (
        .clk      (clk),
        .rst      (rst),
        .alm_ld   (alm_ld_i),
        .alm_val  (cal_time_t'(alm_val_i)),
        .mask_ld  (mask_ld_i),
        .mask_val (mask_val_i),
        .probe    (nxt_time),
        .match    (alm_match)
    );

    cal_irq_ctrl u_irq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_i),
        .time_ld (time_ld_i),
        .match   (alm_match),
        .ien_ld  (ien_ld_i),
        .ien_val (ien_val_i),
        .sts_rd  (sts_rd_i),
        .sts     (sts_o),
        .ien     (ien_o),
        .irq_n   (irq_n_o)
    );

    assign time_o = cur_time;

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
    import cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_i,
    input logic              time_ld_i,
    input logic [TIME_W-1:0] time_val_i,
    input logic              ien_ld_i,
    input logic              sts_rd_i,
    input logic [TIME_W-1:0] time_o,
    input logic [ST_W-1:0]   sts_o,
    input logic [EN_W-1:0]   ien_o
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (sts_o == '0 && ien_o == '0 && time_o == TIME_RESET));

    a_r2_load_visible: assert property (@(posedge clk) disable iff (rst)
        time_ld_i |=> time_o == $past(time_val_i));

    a_r3_sec_step: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !time_ld_i && time_o[SEC_W-1:0] < SEC_W'(59))
        |=> time_o[SEC_W-1:0] == $past(time_o[SEC_W-1:0]) + SEC_W'(1));

    a_r6_alarm_needs_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_o[ST_ALARM]) |-> $past(tick_i));

    a_r7_tick_flag: assert property (@(posedge clk) disable iff (rst)
        (tick_i && ien_o[EN_TICK]) |=> sts_o[ST_TICK]);

    a_r8_oneshot_only: assert property (@(posedge clk) disable iff (rst)
        $fell(ien_o[EN_ALARM]) |-> ($past(ien_o[EN_ONESHOT]) || $past(ien_ld_i)));

    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (sts_rd_i && !tick_i) |=> sts_o == '0);

endmodule

bind cal_alarm_top cal_alarm_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .time_ld_i  (time_ld_i),
    .time_val_i (time_val_i),
    .ien_ld_i   (ien_ld_i),
    .sts_rd_i   (sts_rd_i),
    .time_o     (time_o),
    .sts_o      (sts_o),
    .ien_o      (ien_o)
);

// File: tb/cal_alarm_top_tb.sv
module cal_alarm_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        time_ld_i = 1'b0;
    logic [35:0] time_val_i = '0;
    logic        alm_ld_i = 1'b0;
    logic [35:0] alm_val_i = '0;
    logic        mask_ld_i = 1'b0;
    logic [6:0]  mask_val_i = '0;
    logic        ien_ld_i = 1'b0;
    logic [2:0]  ien_val_i = '0;
    logic        sts_rd_i = 1'b0;
    logic [35:0] time_o;
    logic [1:0]  sts_o;
    logic [2:0]  ien_o;
    logic        irq_n_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cal_alarm_top u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i),
        .time_ld_i(time_ld_i), .time_val_i(time_val_i),
        .alm_ld_i(alm_ld_i), .alm_val_i(alm_val_i),
        .mask_ld_i(mask_ld_i), .mask_val_i(mask_val_i),
        .ien_ld_i(ien_ld_i), .ien_val_i(ien_val_i),
        .sts_rd_i(sts_rd_i),
        .time_o(time_o), .sts_o(sts_o), .ien_o(ien_o), .irq_n_o(irq_n_o)
    );

    function automatic logic [35:0] pk(int y, int mo, int wd, int d, int h, int mi, int s);
        return {7'(y), 4'(mo), 3'(wd), 5'(d), 5'(h), 6'(mi), 6'(s)};
    endfunction

    function automatic int ref_dim(int mo, int y);
        if (mo == 2) return ((y % 4) == 0 && y != 100) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [35:0] model_next(logic [35:0] t);
        int s  = int'(t[5:0]);
        int mi = int'(t[11:6]);
        int h  = int'(t[16:12]);
        int d  = int'(t[21:17]);
        int wd = int'(t[24:22]);
        int mo = int'(t[28:25]);
        int y  = int'(t[35:29]);
        s = s + 1;
        if (s == 60) begin
            s = 0; mi = mi + 1;
            if (mi == 60) begin
                mi = 0; h = h + 1;
                if (h == 24) begin
                    h = 0;
                    wd = (wd % 7) + 1;
                    d = d + 1;
                    if (d > ref_dim(mo, y)) begin
                        d = 1; mo = mo + 1;
                        if (mo == 13) begin
                            mo = 1; y = (y + 1) % 128;
                        end
                    end
                end
            end
        end
        return pk(y, mo, wd, d, h, mi, s);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_time(input logic [35:0] t);
        @(negedge clk); time_ld_i = 1'b1; time_val_i = t;
        @(negedge clk); time_ld_i = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
    endtask

    task automatic set_ien(input logic [2:0] v);
        @(negedge clk); ien_ld_i = 1'b1; ien_val_i = v;
        @(negedge clk); ien_ld_i = 1'b0;
    endtask

    task automatic set_alarm(input logic [35:0] a, input logic [6:0] m);
        @(negedge clk); alm_ld_i = 1'b1; alm_val_i = a; mask_ld_i = 1'b1; mask_val_i = m;
        @(negedge clk); alm_ld_i = 1'b0; mask_ld_i = 1'b0;
    endtask

    task automatic read_sts();
        @(negedge clk); sts_rd_i = 1'b1;
        @(negedge clk); sts_rd_i = 1'b0;
    endtask

    function automatic int year_pick(int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 4;
            3: return 99;
            4: return 100;
            default: return 127;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [35:0] t;
        logic [35:0] ta;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        chk(time_o == pk(0, 1, 1, 1, 0, 0, 0), "R1 time", time_o, pk(0, 1, 1, 1, 0, 0, 0));
        chk(sts_o == 2'b00 && ien_o == 3'b000, "R1 sts/ien", {31'd0, sts_o, ien_o}, '0);
        chk(irq_n_o == 1'b1, "R1 irq_n", {35'd0, irq_n_o}, 36'd1);

        // R2 load wins over simultaneous tick
        t = pk(5, 3, 2, 10, 8, 30, 15);
        @(negedge clk); time_ld_i = 1'b1; tick_i = 1'b1; time_val_i = t;
        @(negedge clk); time_ld_i = 1'b0; tick_i = 1'b0;
        chk(time_o == t, "R2 load priority", time_o, t);

        // R4 R5 day/month/year sweep at 23:59:59
        for (int yi = 0; yi < 6; yi++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                for (int d = 1; d <= ref_dim(mo, year_pick(yi)); d++) begin
                    t = pk(year_pick(yi), mo, (d % 7) + 1, d, 23, 59, 59);
                    load_time(t);
                    do_tick();
                    chk(time_o == model_next(t), "R4 R5 day end", time_o, model_next(t));
                end
            end
        end

        // R3 continuous run across seconds, minutes and hours
        t = pk(20, 2, 7, 28, 22, 58, 30);
        load_time(t);
        for (int i = 0; i < 4000; i++) begin
            do_tick();
            t = model_next(t);
            chk(time_o == t, "R3 carry run", time_o, t);
        end

        // R7 R10 tick flag and interrupt
        set_ien(3'b010);
        do_tick();
        chk(sts_o == 2'b10, "R7 tick flag", {34'd0, sts_o}, 36'd2);
        chk(irq_n_o == 1'b0, "R10 irq low", {35'd0, irq_n_o}, 36'd0);
        // R9 read clears
        read_sts();
        chk(sts_o == 2'b00, "R9 read clear", {34'd0, sts_o}, 36'd0);
        chk(irq_n_o == 1'b1, "R10 irq high", {35'd0, irq_n_o}, 36'd1);
        // R9 set wins over read
        @(negedge clk); sts_rd_i = 1'b1; tick_i = 1'b1;
        @(negedge clk); sts_rd_i = 1'b0; tick_i = 1'b0;
        chk(sts_o[1] == 1'b1, "R9 set wins", {35'd0, sts_o[1]}, 36'd1);
        read_sts();
        // R7 tick disabled
        set_ien(3'b000);
        do_tick();
        chk(sts_o == 2'b00, "R7 tick gated", {34'd0, sts_o}, 36'd0);
        chk(irq_n_o == 1'b1, "R10 irq idle", {35'd0, irq_n_o}, 36'd1);

        // R6 alarm with day-of-week mismatch, unmasked: no hit
        ta = pk(9, 6, 3, 14, 12, 0, 0);
        set_alarm(pk(9, 6, 5, 14, 12, 0, 1), 7'b0000000);
        set_ien(3'b001);
        load_time(ta);
        do_tick();
        chk(sts_o[0] == 1'b0, "R6 wday compared", {35'd0, sts_o[0]}, 36'd0);
        // R6 mask bit 4 removes day of week
        set_alarm(pk(9, 6, 5, 14, 12, 0, 1), 7'b0010000);
        load_time(ta);
        do_tick();
        chk(sts_o[0] == 1'b1, "R6 wday masked hit", {35'd0, sts_o[0]}, 36'd1);
        chk(time_o == model_next(ta), "R6 time at hit", time_o, model_next(ta));
        chk(irq_n_o == 1'b0, "R10 alarm irq", {35'd0, irq_n_o}, 36'd0);
        chk(ien_o == 3'b001, "R8 enable kept w/o one-shot", {33'd0, ien_o}, 36'd1);
        read_sts();
        do_tick();
        chk(sts_o[0] == 1'b0, "R6 single hit", {35'd0, sts_o[0]}, 36'd0);
        // R6 seconds masked: matches at 12:00:41
        set_alarm(pk(9, 6, 5, 14, 12, 0, 1), 7'b0010001);
        load_time(pk(9, 6, 3, 14, 12, 0, 40));
        do_tick();
        chk(sts_o[0] == 1'b1, "R6 sec masked hit", {35'd0, sts_o[0]}, 36'd1);
        read_sts();
        // R6 alarm disabled
        set_alarm(pk(9, 6, 5, 14, 12, 0, 1), 7'b0010000);
        set_ien(3'b000);
        load_time(ta);
        do_tick();
        chk(sts_o[0] == 1'b0, "R6 alarm gated", {35'd0, sts_o[0]}, 36'd0);

        // R8 one-shot
        set_ien(3'b101);
        load_time(ta);
        do_tick();
        chk(sts_o[0] == 1'b1, "R8 one-shot hit", {35'd0, sts_o[0]}, 36'd1);
        chk(ien_o == 3'b100, "R8 one-shot disarm", {33'd0, ien_o}, 36'd4);
        read_sts();
        load_time(ta);
        do_tick();
        chk(sts_o[0] == 1'b0, "R8 no second hit", {35'd0, sts_o[0]}, 36'd0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule